// File: doc/BRIEF.md
# Float-to-Integer Truncating Converter

This block turns a floating-point value, already unpacked into a class, a sign, an unbiased exponent and a normalised mantissa, into a signed two's-complement integer. The integer width is a parameter, 32 or 64 bits. The conversion always truncates toward zero. No rounding-mode input exists, so the active rounding mode of the surrounding unit has no effect on the result. Each accepted input produces one registered result one cycle later. The result carries an inexact flag and an invalid flag.

A value whose integer part does not fit gives the saturated integer for its sign: the largest positive value or the most negative value. Infinity and NaN give the same saturated result. The overflow limit depends on the sign. A negative value whose magnitude is exactly 2^(N-1) converts normally to the most negative integer. The same magnitude with a positive sign overflows.

Top module: `fp2int_trunc`

## Requirements
- R1: A zero-class input (class code 2'b00) gives an integer of 0 with both flags clear, whatever the sign.
- R2: A number-class input (class code 2'b01) has the value in_mant * 2^(in_exp - (MANT_W-1)), with in_mant[MANT_W-1] set. When no overflow occurs, the result magnitude is the integer part of that value, truncated toward zero, for both signs.
- R3: When no overflow occurs, out_inexact is set exactly when some nonzero mantissa bit lies below the binary point.
- R4: A number with a negative exponent gives 0, with out_inexact set and out_invalid clear.
- R5: A number with an exponent greater than or equal to INT_W is an overflow.
- R6: A positive number overflows when its truncated magnitude is at least 2^(INT_W-1). A negative number overflows when its truncated magnitude is greater than 2^(INT_W-1). A negative magnitude of exactly 2^(INT_W-1) gives the most negative integer with out_invalid clear.
- R7: Infinity (class 2'b10) and NaN (class 2'b11) are handled as overflow, with the result saturated according to in_sign.
- R8: On overflow, out_invalid is set, out_inexact is clear, and out_int is 2^(INT_W-1)-1 plus the sign bit. That gives all ones below a clear top bit for positive inputs, and only the top bit set for negative inputs.
- R9: A negative, non-overflowing result is the two's-complement negation of the truncated magnitude.
- R10: out_valid is high in the cycle after a cycle with in_valid high, and low otherwise. The outputs change only after an accepted input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input value present this cycle |
| in_class | input | 2 | 00 zero, 01 number, 10 infinity, 11 NaN |
| in_sign | input | 1 | Sign, 1 is negative |
| in_exp | input | EXP_W | Unbiased exponent, signed |
| in_mant | input | MANT_W | Normalised mantissa, leading one at the MSB |
| out_valid | output | 1 | Result present |
| out_int | output | INT_W | Two's-complement integer result |
| out_inexact | output | 1 | Discarded fraction bits were nonzero |
| out_invalid | output | 1 | Overflow, infinity or NaN |

## Verification
The hardest conditions to reach are an exact conversion, which needs every fraction bit zero, and the magnitude of exactly 2^(INT_W-1), where the two signs must give different results. A random normalised mantissa almost never meets either condition. The stimulus therefore clears every bit below the binary point on a share of the random vectors. Directed vectors place the mantissa exactly at the limit and one unit above it, for both signs.

// File: rtl/fp2int_trunc.sv
`timescale 1ns/1ps
module fp2int_trunc #(
  parameter int INT_W  = 32,
  parameter int MANT_W = 64,
  parameter int EXP_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [1:0]              in_class,
  input  logic                    in_sign,
  input  logic signed [EXP_W-1:0] in_exp,
  input  logic [MANT_W-1:0]       in_mant,
  output logic                    out_valid,
  output logic [INT_W-1:0]        out_int,
  output logic                    out_inexact,
  output logic                    out_invalid
);
  localparam int SH_W = $clog2(MANT_W);
  localparam logic [1:0] CLS_ZERO = 2'b00;
  localparam logic [1:0] CLS_NUM  = 2'b01;
  localparam logic signed [EXP_W-1:0] EXP_LIM = EXP_W'(INT_W);

  logic              exp_neg, exp_big, lost, mag_ovf;
  logic [SH_W-1:0]   shamt;
  logic [MANT_W-1:0] shifted, lost_mask;
  logic [INT_W-1:0]  mag, sat, res_d;
  logic              nx_d, nv_d;

  assign exp_neg   = in_exp[EXP_W-1];
  assign exp_big   = in_exp >= EXP_LIM;
  assign shamt     = SH_W'(MANT_W-1) - in_exp[SH_W-1:0];
  assign shifted   = in_mant >> shamt;
  assign lost_mask = ~({MANT_W{1'b1}} << shamt);
  assign lost      = |(in_mant & lost_mask);
  assign mag       = shifted[INT_W-1:0];
  assign mag_ovf   = mag[INT_W-1] && (!in_sign || |mag[INT_W-2:0]);
  assign sat       = {in_sign, {(INT_W-1){~in_sign}}};

  always_comb begin
    res_d = sat;
    nx_d  = 1'b0;
    nv_d  = 1'b1;
    if (in_class == CLS_ZERO) begin
      res_d = '0;
      nv_d  = 1'b0;
    end else if (in_class == CLS_NUM) begin
      if (exp_neg) begin
        res_d = '0;
        nx_d  = |in_mant;
        nv_d  = 1'b0;
      end else if (!exp_big && !mag_ovf) begin
        res_d = in_sign ? (~mag + 1'b1) : mag;
        nx_d  = lost;
        nv_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_int     <= '0;
      out_inexact <= 1'b0;
      out_invalid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_int     <= res_d;
        out_inexact <= nx_d;
        out_invalid <= nv_d;
      end
    end
  end

  // R1
  zero_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_class == CLS_ZERO |=> out_int == '0 && !out_inexact && !out_invalid);
  // R7
  nonfinite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_class[1] |=> out_invalid && out_int[INT_W-1] == $past(in_sign));
  // R8
  sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_invalid |-> !out_inexact && out_int == {out_int[INT_W-1], {(INT_W-1){~out_int[INT_W-1]}}});
  // R9
  sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_class == CLS_NUM |=> out_invalid || out_int == '0 || out_int[INT_W-1] == $past(in_sign));
  // R10
  valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_int) && $stable(out_inexact) && $stable(out_invalid));
  // R4
  neg_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_class == CLS_NUM && in_exp < 0 |=> out_int == '0 && out_inexact && !out_invalid);
endmodule

// File: tb/sim_fp2int_trunc.sv
`timescale 1ns/1ps
module sim_fp2int_trunc;
  localparam int IW = 32, MW = 64, EW = 12;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_sign = 1'b0;
  logic [1:0] in_class = 2'b00;
  logic signed [EW-1:0] in_exp = '0;
  logic [MW-1:0] in_mant = '0;
  logic out_valid, out_inexact, out_invalid;
  logic [IW-1:0] out_int;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  fp2int_trunc #(.INT_W(IW), .MANT_W(MW), .EXP_W(EW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
    .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant), .out_valid(out_valid),
    .out_int(out_int), .out_inexact(out_inexact), .out_invalid(out_invalid));

  function automatic logic [IW+1:0] model(input logic [1:0] c, input logic s,
                                          input int e, input logic [MW-1:0] m);
    logic [IW-1:0] r;
    logic nx, nv;
    logic [63:0] mg;
    mg = 0; nx = 0; nv = 0; r = 0;
    if (c == 2'b00) return '0;
    if (c != 2'b01 || e >= IW) nv = 1;
    else if (e < 0) nx = (m != 0);
    else begin
      for (int i = 0; i < MW; i++) begin
        if (i <= e) mg = mg * 2 + 64'(m[MW-1-i]);
        else if (m[MW-1-i]) nx = 1;
      end
      if (mg > 64'h8000_0000 || (mg == 64'h8000_0000 && !s)) nv = 1;
      else r = s ? IW'(64'd0 - mg) : IW'(mg);
    end
    if (nv) begin
      nx = 0;
      r = 32'h7FFF_FFFF + IW'(s);
    end
    return {r, nx, nv};
  endfunction

  task automatic check_out(input string tag, input logic [IW+1:0] exp_v);
    checks++;
    if (!out_valid || {out_int, out_inexact, out_invalid} !== exp_v) begin
      errors++;
      $display("FAIL %s: got valid=%0b int=%h nx=%0b nv=%0b expected valid=1 int=%h nx=%0b nv=%0b",
               tag, out_valid, out_int, out_inexact, out_invalid,
               exp_v[IW+1:2], exp_v[1], exp_v[0]);
    end
  endtask

  task automatic apply(input string tag, input logic [1:0] c, input logic s,
                       input int e, input logic [MW-1:0] m);
    logic [IW+1:0] ev;
    ev = model(c, s, e, m);
    @(negedge clk);
    in_valid = 1; in_class = c; in_sign = s; in_exp = EW'(e); in_mant = m;
    @(negedge clk);
    in_valid = 0;
    check_out(tag, ev);
  endtask

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [IW+1:0] held;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 0 || out_int !== 0 || out_inexact !== 0 || out_invalid !== 0) begin
      errors++;
      $display("FAIL R10 reset: got valid=%0b int=%h expected valid=0 int=0", out_valid, out_int);
    end
    rst_n = 1;
    apply("R1 zero pos", 2'b00, 0, 5, 64'h0);
    apply("R1 zero neg", 2'b00, 1, 40, 64'h0);
    apply("R2 exact one", 2'b01, 0, 0, 64'h8000_0000_0000_0000);
    apply("R3 1.5 pos", 2'b01, 0, 0, 64'hC000_0000_0000_0000);
    apply("R9 1.5 neg", 2'b01, 1, 0, 64'hC000_0000_0000_0000);
    apply("R3 lowest bit", 2'b01, 0, 3, 64'h8000_0000_0000_0001);
    apply("R4 half", 2'b01, 0, -1, 64'h8000_0000_0000_0000);
    apply("R4 tiny neg", 2'b01, 1, -30, 64'hFFFF_0000_0000_0000);
    apply("R5 exp=INT_W", 2'b01, 0, 32, 64'h8000_0000_0000_0000);
    apply("R5 large neg", 2'b01, 1, 100, 64'h8000_0000_0000_0000);
    apply("R6 pos at limit", 2'b01, 0, 31, 64'h8000_0000_0000_0000);
    apply("R6 neg at limit", 2'b01, 1, 31, 64'h8000_0000_0000_0000);
    apply("R6 neg at limit frac", 2'b01, 1, 31, 64'h8000_0000_0000_0001);
    apply("R6 neg above limit", 2'b01, 1, 31, 64'h8000_0001_0000_0000);
    apply("R6 pos max", 2'b01, 0, 30, 64'hFFFF_FFFF_0000_0000);
    apply("R7 inf pos", 2'b10, 0, 0, 64'h0);
    apply("R7 inf neg", 2'b10, 1, 0, 64'h0);
    apply("R8 nan neg", 2'b11, 1, 7, 64'hC000_0000_0000_0000);
    apply("R8 nan pos", 2'b11, 0, 7, 64'hC000_0000_0000_0001);
    held = {out_int, out_inexact, out_invalid};
    @(negedge clk);
    checks++;
    if (out_valid !== 0 || {out_int, out_inexact, out_invalid} !== held) begin
      errors++;
      $display("FAIL R10 hold: got valid=%0b int=%h expected valid=0 int=%h",
               out_valid, out_int, held[IW+1:2]);
    end
    for (int k = 0; k < 400; k++) begin
      int e;
      logic [MW-1:0] m;
      e = int'($urandom_range(38)) - 4;
      m = {1'b1, 31'($urandom), 32'($urandom)};
      if (($urandom & 3) == 0 && e >= 0 && e < 63) m = m & ~(64'hFFFF_FFFF_FFFF_FFFF >> (e + 1));
      apply("R2 R3 random", 2'b01, 1'($urandom), e, m);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule